// File: doc/BRIEF.md
# DMA Interrupt Register Block

This block holds the interrupt state of a seven-channel DMA engine. It keeps a force bit, a per-channel enable mask, a master enable, seven pending flags and six bits of spare storage. From these it forms a single interrupt request. It also holds a separate 32-bit priority/control word with a fixed reset value. The DMA engine raises a channel's pending flag with a one-cycle completion pulse. Software clears pending flags by writing ones to them.

Software reaches both registers through one 32-bit port. `reg_sel` picks the word: 0 is the interrupt register and 1 is the control register. A write happens on a clock edge where `wr_en` is high. The read data is combinational from the stored state. For a system interrupt controller that needs edges, the block gives a one-cycle pulse each time the request rises.

Top module: `dma_irq_regs`

## Requirements
- R1: While reset is active and after it is released, the interrupt register reads 0x00000000, `irq` and `irq_edge` are low, and the control register reads 0x07654321.
- R2: A write to the interrupt register (`reg_sel`=0) stores the written bits 5:0 (spare), bit 15 (force), bits 22:16 (enable for channels 0..6) and bit 23 (master enable), and these read back at the same positions. Bits 14:6 always read zero.
- R3: `irq` is high when force is set. When force is clear, `irq` is high only if master enable is set and at least one channel has both its pending flag and its enable set.
- R4: Bit 31 of the interrupt register reads the current `irq` value, and a write to bit 31 has no effect.
- R5: Pending flags for channels 0..5 read at bits 29:24. Writing a one to bit 24+k clears flag k. Writing a zero leaves the flag unchanged.
- R6: The flag for channel 6 reads at bit 30. No write clears it, and writing a one to bit 30 leaves it set.
- R7: A high pulse on `done_pulse[k]` sets pending flag k on that clock edge, whatever the state of its enable bit.
- R8: If a completion pulse and an acknowledge write reach the same flag on the same edge, the flag is set after the edge.
- R9: A write with `reg_sel`=1 stores all 32 bits into the control register unchanged, and does not alter the interrupt register.
- R10: `irq_edge` is high for exactly the first cycle in which `irq` is high after being low, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 1 | Register select: 0 interrupt register, 1 control register |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| done_pulse | input | 7 | Per-channel completion pulses from the DMA engine |
| irq | output | 1 | Interrupt request level |
| irq_edge | output | 1 | One-cycle pulse on each rising edge of `irq` |

## Verification
The hardest case is a completion pulse that lands on the same edge as an acknowledge write to the same flag. Here the set must win over the clear. The bench drives both in one vector, with the channel enabled, and checks that the flag stays set and the request stays high. A second hard case is the seventh flag. Only a stream of writes can show that it can never be acknowledged. So the bench writes all-ones acknowledge patterns, and one pattern with only bit 30 set, while that flag is pending. It then checks the read-back after each write.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_CH     = 7;
  localparam int ACK_CH     = 6;
  localparam int SPARE_W    = 6;
  localparam int FORCE_BIT  = 15;
  localparam int EN_LSB     = 16;
  localparam int MASTER_BIT = 23;
  localparam int PEND_LSB   = 24;
  localparam int STAT_BIT   = 31;
  localparam logic [DATA_W-1:0] CTRL_RST = 32'h0765_4321;

  typedef struct packed {
    logic [SPARE_W-1:0] spare;
    logic               force_irq;
    logic [NUM_CH-1:0]  ch_en;
    logic               master;
  } irq_cfg_t;

  function automatic logic [DATA_W-1:0] pack_word(input irq_cfg_t cfg,
                                                  input logic [NUM_CH-1:0] pend,
                                                  input logic req);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SPARE_W-1:0]               = cfg.spare;
    w[FORCE_BIT]                 = cfg.force_irq;
    w[EN_LSB +: NUM_CH]          = cfg.ch_en;
    w[MASTER_BIT]                = cfg.master;
    w[PEND_LSB +: NUM_CH]        = pend;
    w[STAT_BIT]                  = req;
    return w;
  endfunction
endpackage

// File: rtl/dmairq_rst_sync.sv
module dmairq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dmairq_field_regs.sv
module dmairq_field_regs
  import dmairq_pkg::*;
#(
  parameter int N_CH   = NUM_CH,
  parameter int N_ACK  = ACK_CH
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic             wr_fire,
  input  irq_cfg_t         cfg_wr,
  input  logic [N_ACK-1:0] ack_wr,
  input  logic [N_CH-1:0]  done_pulse,
  output irq_cfg_t         cfg_q,
  output logic [N_CH-1:0]  pend_q
);
  irq_cfg_t        cfg_d;
  logic            cfg_load;
  logic [N_CH-1:0] pend_d;
  logic [N_CH-1:0] clr;

  // configuration fields: next state
  always_comb begin
    cfg_load = wr_fire;
    cfg_d    = cfg_q;
    if (cfg_load) cfg_d = cfg_wr;
  end

  // pending flags: per-channel set/clear, set dominant
  for (genvar i = 0; i < N_CH; i++) begin : g_flag
    if (i < N_ACK) begin : g_ackable
      assign clr[i] = wr_fire & ack_wr[i];
    end else begin : g_sticky
      assign clr[i] = 1'b0;
    end
    assign pend_d[i] = done_pulse[i] | (pend_q[i] & ~clr[i]);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q  <= '0;
      pend_q <= '0;
    end else begin
      if (cfg_load) cfg_q <= cfg_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/dmairq_req.sv
module dmairq_req
  import dmairq_pkg::*;
#(
  parameter int N_CH = NUM_CH
) (
  input  logic            clk,
  input  logic            rst_sync_n,
  input  logic            force_irq,
  input  logic            master,
  input  logic [N_CH-1:0] ch_en,
  input  logic [N_CH-1:0] pend,
  output logic            irq,
  output logic            irq_edge
);
  logic masked_any;
  logic irq_prev_q;
  logic irq_prev_d;

  always_comb begin
    masked_any = |(pend & ch_en);
    irq        = force_irq | (master & masked_any);
    irq_prev_d = irq;
    irq_edge   = irq & ~irq_prev_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_prev_q <= 1'b0;
    else             irq_prev_q <= irq_prev_d;
  end
endmodule

// File: rtl/dmairq_ctrl_reg.sv
module dmairq_ctrl_reg
  import dmairq_pkg::*;
#(
  parameter int                W       = DATA_W,
  parameter logic [W-1:0]      RST_VAL = CTRL_RST
) (
  input  logic         clk,
  input  logic         rst_sync_n,
  input  logic         wr_fire,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ctrl_q
);
  logic [W-1:0] ctrl_d;
  logic         ctrl_load;

  always_comb begin
    ctrl_load = wr_fire;
    ctrl_d    = ctrl_load ? wr_data : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    ctrl_q <= RST_VAL;
    else if (ctrl_load) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dmairq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_CH-1:0] done_pulse,
  output logic              irq,
  output logic              irq_edge
);
  logic              rst_sync_n;
  logic              wr_irq;
  logic              wr_ctrl;
  irq_cfg_t          cfg_wr;
  irq_cfg_t          cfg_q;
  logic [ACK_CH-1:0] ack_wr;
  logic [NUM_CH-1:0] pend_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] irq_word;
  logic              force_q;
  logic              master_q;

  dmairq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    wr_irq           = wr_en & ~reg_sel;
    wr_ctrl          = wr_en &  reg_sel;
    cfg_wr.spare     = wr_data[SPARE_W-1:0];
    cfg_wr.force_irq = wr_data[FORCE_BIT];
    cfg_wr.ch_en     = wr_data[EN_LSB +: NUM_CH];
    cfg_wr.master    = wr_data[MASTER_BIT];
    ack_wr           = wr_data[PEND_LSB +: ACK_CH];
  end

  dmairq_field_regs #(.N_CH(NUM_CH), .N_ACK(ACK_CH)) u_fields (
    .clk(clk), .rst_sync_n(rst_sync_n), .wr_fire(wr_irq),
    .cfg_wr(cfg_wr), .ack_wr(ack_wr), .done_pulse(done_pulse),
    .cfg_q(cfg_q), .pend_q(pend_q)
  );

  assign force_q  = cfg_q.force_irq;
  assign master_q = cfg_q.master;

  dmairq_req #(.N_CH(NUM_CH)) u_req (
    .clk(clk), .rst_sync_n(rst_sync_n),
    .force_irq(force_q), .master(master_q), .ch_en(cfg_q.ch_en),
    .pend(pend_q), .irq(irq), .irq_edge(irq_edge)
  );

  dmairq_ctrl_reg #(.W(DATA_W), .RST_VAL(CTRL_RST)) u_ctrl (
    .clk(clk), .rst_sync_n(rst_sync_n), .wr_fire(wr_ctrl),
    .wr_data(wr_data), .ctrl_q(ctrl_q)
  );

  always_comb begin
    irq_word = pack_word(cfg_q, pend_q, irq);
    rd_data  = reg_sel ? ctrl_q : irq_word;
  end
endmodule

// File: rtl/dma_irq_regs_chk.sv
module dma_irq_regs_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        reg_sel,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic [6:0]  done_pulse,
  input logic [6:0]  pend_q,
  input logic        force_q,
  input logic        master_q,
  input logic [31:0] ctrl_q,
  input logic        irq,
  input logic        irq_edge
);
  // R3
  force_drives_irq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    force_q |-> irq);

  // R3
  no_master_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!force_q && !master_q) |-> !irq);

  // R4
  status_bit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !reg_sel |-> (rd_data[31] == irq));

  // R6
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pend_q[6] |=> pend_q[6]);

  // R7
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|done_pulse) |=> ((pend_q & $past(done_pulse)) == $past(done_pulse)));

  // R5
  clear_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(pend_q[0]) |-> $past(wr_en && !reg_sel && wr_data[24]));

  // R9
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && reg_sel) |=> (ctrl_q == $past(wr_data)));

  // R10
  edge_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_edge |-> (irq && !$past(irq)));

  // R10
  rise_gives_edge_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq) |-> irq_edge);
endmodule

bind dma_irq_regs dma_irq_regs_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .reg_sel(reg_sel), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .done_pulse(done_pulse),
  .pend_q(pend_q), .force_q(force_q), .master_q(master_q), .ctrl_q(ctrl_q),
  .irq(irq), .irq_edge(irq_edge)
);

// File: tb/dma_irq_regs_tb_top.sv
module dma_irq_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        reg_sel;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [6:0]  done_pulse;
  logic        irq;
  logic        irq_edge;

  int checks = 0;
  int errors = 0;

  dma_irq_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .done_pulse(done_pulse),
    .irq(irq), .irq_edge(irq_edge)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        sel;
    logic        we;
    logic [31:0] data;
    logic [6:0]  done;
    logic [31:0] exp_word;
    logic        exp_irq;
  } vec_t;

  // word = irq<<31 | flags<<24 | master<<23 | enables<<16 | force<<15 | spare
  localparam vec_t VECS [12] = '{
    '{1'b0, 1'b1, 32'h0000_003F, 7'h00, 32'h0000_003F, 1'b0}, // R2 spare
    '{1'b0, 1'b1, 32'hFFFF_FFC0, 7'h00, 32'h80FF_8000, 1'b1}, // R2 R3 R4 force
    '{1'b0, 1'b1, 32'h0000_0000, 7'h00, 32'h0000_0000, 1'b0}, // R2 clear
    '{1'b0, 1'b0, 32'h0000_0000, 7'h41, 32'h4100_0000, 1'b0}, // R7 no enable
    '{1'b0, 1'b1, 32'h0082_0000, 7'h00, 32'h4182_0000, 1'b0}, // R3 mask miss
    '{1'b0, 1'b1, 32'h00C0_0000, 7'h00, 32'hC1C0_0000, 1'b1}, // R3 mask hit
    '{1'b0, 1'b1, 32'h40C0_0000, 7'h00, 32'hC1C0_0000, 1'b1}, // R6 bit30 only
    '{1'b0, 1'b1, 32'h3FC0_0000, 7'h00, 32'hC0C0_0000, 1'b1}, // R5 R6 ack all
    '{1'b0, 1'b1, 32'h0080_0000, 7'h04, 32'h4480_0000, 1'b0}, // R7
    '{1'b0, 1'b1, 32'h0484_0000, 7'h04, 32'hC484_0000, 1'b1}, // R8 collide
    '{1'b0, 1'b1, 32'h0484_0000, 7'h00, 32'h4084_0000, 1'b0}, // R5 ack
    '{1'b1, 1'b1, 32'hDEAD_BEEF, 7'h00, 32'h4084_0000, 1'b0}  // R9 no effect
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic sel, input logic we, input logic [31:0] d,
                      input logic [6:0] dn);
    @(negedge clk);
    reg_sel = sel; wr_en = we; wr_data = d; done_pulse = dn;
    @(posedge clk);
    #2;
    wr_en = 1'b0; done_pulse = '0; reg_sel = 1'b0; wr_data = '0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_sel = 1'b0; wr_en = 1'b0; wr_data = '0; done_pulse = '0;
    repeat (3) @(posedge clk);
    #3;
    check("R1 word in reset", rd_data, 32'h0);
    check("R1 irq in reset", {31'b0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #3;
    check("R1 word after reset", rd_data, 32'h0);
    check("R1 edge after reset", {31'b0, irq_edge}, 32'h0);
    reg_sel = 1'b1; #1;
    check("R1 ctrl reset value", rd_data, 32'h0765_4321);
    reg_sel = 1'b0;

    for (int i = 0; i < 12; i++) begin
      step(VECS[i].sel, VECS[i].we, VECS[i].data, VECS[i].done);
      check($sformatf("vec %0d word (R2..R9)", i), rd_data, VECS[i].exp_word);
      check($sformatf("vec %0d irq (R3)", i), {31'b0, irq}, {31'b0, VECS[i].exp_irq});
    end

    // R9 control read-back
    reg_sel = 1'b1; #1;
    check("R9 ctrl read", rd_data, 32'hDEAD_BEEF);
    reg_sel = 1'b0;

    // R10 edge pulse: force on from irq low
    step(1'b0, 1'b1, 32'h0084_8000, 7'h00);
    check("R10 edge first cycle", {30'b0, irq, irq_edge}, 32'h3);
    step(1'b0, 1'b0, 32'h0, 7'h00);
    check("R10 edge second cycle", {30'b0, irq, irq_edge}, 32'h2);
    step(1'b0, 1'b1, 32'h0084_0000, 7'h00);
    check("R10 edge on fall", {30'b0, irq, irq_edge}, 32'h0);

    // R9 second value, R4 write of bit31 ignored
    step(1'b1, 1'b1, 32'h0000_0000, 7'h00);
    reg_sel = 1'b1; #1;
    check("R9 ctrl zero", rd_data, 32'h0);
    reg_sel = 1'b0;
    step(1'b0, 1'b1, 32'h8000_0000, 7'h00);
    check("R4 bit31 not writable", rd_data, 32'h4000_0000);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 word on reset", rd_data, 32'h0);
    reg_sel = 1'b1; #1;
    check("R1 ctrl on reset", rd_data, 32'h0765_4321);
    reg_sel = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule